// File: doc/BRIEF.md
# Gigabit PHY link-configuration register with deferred commit

This block is a 16-bit control register for a gigabit copper PHY, written and read through a plain register port. It has two parts. A three-bit test-mode field in the top bits is used as soon as it is written. Five link-configuration bits live in bits 12 down to 8: advertise half duplex, advertise full duplex, prefer master (port type), manual master/slave value, and manual master/slave enable. Writes to these five bits go to a pending copy, which is what a read returns. An active copy drives the PHY core. The active copy loads from the pending copy only when a commit event occurs.

A commit event is any of the following, seen in the same clock cycle:
- a software-reset pulse,
- a restart-negotiation pulse,
- a falling edge of the power-down level,
- a falling edge of the link-up level.

If a write and a commit event arrive in the same cycle, the value written that cycle is the one committed. A two-state machine follows whether the pending copy differs from the active copy:
- **ST_SYNCED** moves to **ST_HELD** on a write with no commit event (transition *hold*).
- **ST_HELD** returns to **ST_SYNCED** on any commit event (transition *commit*).
- In **ST_SYNCED**, a write together with a commit event loads the active copy directly and the machine stays in **ST_SYNCED** (transition *pass-through*).

After a hardware reset, the master/slave value and the port preference take the master/slave strap. Half-duplex advertisement takes bit 0 of the negotiation strap.

Top module: `gphy_cfg_reg`

## Requirements
- R1: After hardware reset, rd_data has these values: bits 15:13 = 0, bit 12 = 0, bits 11 and 10 = strap_ms, bit 9 = 1, bit 8 = strap_aneg[0], and bits 7:0 = 0. act_cfg holds the same five values as bits 12:8, with act_cfg[4] mapping to bit 12 and act_cfg[0] to bit 8.
- R2: A write with wr_en high stores wr_data[12:8] so that rd_data[12:8] shows it on the next cycle. act_cfg stays unchanged if there is no commit event. wr_data[7:0] is ignored and bits 7:0 always read 0.
- R3: A cycle with sw_reset or an_restart high loads act_cfg with the pending bits. act_cfg shows the new value on the next cycle.
- R4: A 1-to-0 change of pwr_down or of link_up, sampled on consecutive clock edges, commits in the same way as R3. Rising edges and steady levels commit nothing.
- R5: A write in the same cycle as a commit event commits the newly written wr_data[12:8].
- R6: A write stores wr_data[15:13] at once, with no commit event needed. tm_out equals the stored code for codes 0 to 4. Reserved codes 5 to 7 read back unchanged but give tm_out = 0.
- R7: an_restart clears the stored test mode to 0 and wins over a write in the same cycle. sw_reset leaves the test mode unchanged.
- R8: tx_clk_from_rx is 1 exactly when tm_out is 2 or 3.
- R9: The master/slave outputs are derived from act_cfg as follows. ms_manual_en = act_cfg[4]. ms_force_master = act_cfg[4] & act_cfg[3]. ms_prefer_master = act_cfg[2] when act_cfg[4] is 0, and 0 when act_cfg[4] is 1 (the port preference is ignored in manual mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Test mode and pending configuration bits |
| sw_reset | input | 1 | Software-reset pulse (commit event) |
| an_restart | input | 1 | Restart-negotiation pulse (commit event, clears test mode) |
| pwr_down | input | 1 | Power-down level; a falling edge commits |
| link_up | input | 1 | Copper link-up level; a falling edge commits |
| strap_ms | input | 1 | Master/slave strap, used as the reset value |
| strap_aneg | input | 2 | Negotiation strap; bit 0 is the reset value of half-duplex advertisement |
| act_cfg | output | 5 | Active configuration bits in use by the PHY core |
| tm_out | output | 3 | Decoded test mode (reserved codes give 0) |
| tx_clk_from_rx | output | 1 | Selects the receive clock as the transmit clock |
| ms_manual_en | output | 1 | Manual master/slave in effect |
| ms_force_master | output | 1 | Forced master under manual mode |
| ms_prefer_master | output | 1 | Master preference under automatic mode |

## Verification
The assertions assume the straps stay constant while reset is released. They also assume the levels pwr_down and link_up are clean, synchronous signals, so that each 1-to-0 change between two edges is one intended commit event. The stimulus follows both rules: the straps change only while rst_n is low, and every input changes on the falling clock edge. Pulses and levels are otherwise combined freely, including writes that land in the same cycle as every kind of commit event and writes of reserved test-mode codes.

// File: rtl/gphy_cfg_pkg.sv
package gphy_cfg_pkg;

    localparam int CFG_W = 5;

    // Field order matches register bits 12 down to 8.
    typedef struct packed {
        logic manual;
        logic ms_val;
        logic port_pref;
        logic adv_fd;
        logic adv_hd;
    } link_cfg_t;

    typedef enum logic [0:0] {
        ST_SYNCED = 1'b0,
        ST_HELD   = 1'b1
    } commit_st_e;

endpackage

// File: rtl/gphy_fall_detect.sv
module gphy_fall_detect #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] fall
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= lvl[i];
        end
        assign fall[i] = prev_q & ~lvl[i];
    end

endmodule

// File: rtl/gphy_tm_field.sv
module gphy_tm_field #(
    parameter int TM_W   = 3,
    parameter int TM_MAX = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [TM_W-1:0] wr_code,
    input  logic            clear,
    output logic [TM_W-1:0] tm_raw,
    output logic [TM_W-1:0] tm_eff,
    output logic            clk_loop
);

    localparam logic [TM_W-1:0] TM_JIT_M = TM_W'(2);
    localparam logic [TM_W-1:0] TM_JIT_S = TM_W'(3);

    logic [TM_W-1:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     code_q <= '0;
        else if (clear) code_q <= '0;
        else if (wr_en) code_q <= wr_code;
    end

    always_comb begin
        tm_raw   = code_q;
        tm_eff   = (int'(code_q) > TM_MAX) ? '0 : code_q;
        clk_loop = (tm_eff == TM_JIT_M) || (tm_eff == TM_JIT_S);
    end

endmodule

// File: rtl/gphy_commit_fsm.sv
module gphy_commit_fsm
    import gphy_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic commit_evt,
    output logic load_act
);

    commit_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SYNCED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        load_act = 1'b0;
        unique case (state_q)
            ST_SYNCED: begin
                if (wr_en && !commit_evt) state_d = ST_HELD;  // hold
                load_act = wr_en && commit_evt;               // pass-through
            end
            ST_HELD: begin
                if (commit_evt) begin                         // commit
                    state_d  = ST_SYNCED;
                    load_act = 1'b1;
                end
            end
            default: state_d = ST_SYNCED;
        endcase
    end

endmodule

// File: rtl/gphy_cfg_reg.sv
module gphy_cfg_reg
    import gphy_cfg_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int TM_LSB  = 13,
    parameter int CFG_LSB = 8,
    parameter int ANEG_W  = 2,
    parameter int TM_MAX  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sw_reset,
    input  logic              an_restart,
    input  logic              pwr_down,
    input  logic              link_up,
    input  logic              strap_ms,
    input  logic [ANEG_W-1:0] strap_aneg,
    output logic [CFG_W-1:0]  act_cfg,
    output logic [DATA_W-TM_LSB-1:0] tm_out,
    output logic              tx_clk_from_rx,
    output logic              ms_manual_en,
    output logic              ms_force_master,
    output logic              ms_prefer_master
);

    localparam int TM_W  = DATA_W - TM_LSB;
    localparam int CFG_H = CFG_LSB + CFG_W - 1;

    logic [1:0] fall;
    logic       commit_evt;
    logic       load_act;
    link_cfg_t  wr_cfg, pend_q, act_q, rst_cfg;
    logic [TM_W-1:0] tm_raw;

    gphy_fall_detect #(.N(2)) u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({link_up, pwr_down}),
        .fall  (fall)
    );

    assign commit_evt = sw_reset | an_restart | fall[0] | fall[1];

    gphy_commit_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .commit_evt (commit_evt),
        .load_act   (load_act)
    );

    gphy_tm_field #(.TM_W(TM_W), .TM_MAX(TM_MAX)) u_tm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_code  (wr_data[DATA_W-1:TM_LSB]),
        .clear    (an_restart),
        .tm_raw   (tm_raw),
        .tm_eff   (tm_out),
        .clk_loop (tx_clk_from_rx)
    );

    always_comb begin
        wr_cfg            = link_cfg_t'(wr_data[CFG_H:CFG_LSB]);
        rst_cfg.manual    = 1'b0;
        rst_cfg.ms_val    = strap_ms;
        rst_cfg.port_pref = strap_ms;
        rst_cfg.adv_fd    = 1'b1;
        rst_cfg.adv_hd    = strap_aneg[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= rst_cfg;
            act_q  <= rst_cfg;
        end else begin
            if (wr_en)    pend_q <= wr_cfg;
            if (load_act) act_q  <= wr_en ? wr_cfg : pend_q;
        end
    end

    always_comb begin
        rd_data                    = '0;
        rd_data[DATA_W-1:TM_LSB]   = tm_raw;
        rd_data[CFG_H:CFG_LSB]     = pend_q;
        act_cfg                    = act_q;
        ms_manual_en               = act_q.manual;
        ms_force_master            = act_q.manual & act_q.ms_val;
        ms_prefer_master           = ~act_q.manual & act_q.port_pref;
    end

endmodule

// File: rtl/gphy_cfg_reg_chk.sv
module gphy_cfg_reg_chk #(
    parameter int DATA_W  = 16,
    parameter int TM_LSB  = 13,
    parameter int CFG_LSB = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              sw_reset,
    input logic              an_restart,
    input logic              pwr_down,
    input logic              link_up,
    input logic [4:0]        act_cfg,
    input logic [DATA_W-TM_LSB-1:0] tm_out,
    input logic              tx_clk_from_rx,
    input logic              ms_manual_en,
    input logic              ms_prefer_master
);

    logic seen_q, pd_q, lu_q, evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            pd_q   <= 1'b0;
            lu_q   <= 1'b0;
        end else begin
            seen_q <= 1'b1;
            pd_q   <= pwr_down;
            lu_q   <= link_up;
        end
    end

    assign evt = sw_reset | an_restart | (pd_q & ~pwr_down) | (lu_q & ~link_up);

    // R3 R4 R5
    commit_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && evt |=> act_cfg == $past(wr_en ? wr_data[CFG_LSB+4:CFG_LSB] : rd_data[CFG_LSB+4:CFG_LSB]));

    // R2
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && !evt |=> $stable(act_cfg));

    // R7
    tm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        an_restart |=> rd_data[DATA_W-1:TM_LSB] == '0);

    // R6
    tm_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !an_restart |=> rd_data[DATA_W-1:CFG_LSB] == $past(wr_data[DATA_W-1:CFG_LSB]));

    // R8
    loop_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clk_from_rx |-> (rd_data[DATA_W-1:TM_LSB] == 3'd2 || rd_data[DATA_W-1:TM_LSB] == 3'd3));

    // R9
    pref_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ms_manual_en |-> !ms_prefer_master);

    // R2
    low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[CFG_LSB-1:0] == '0);

endmodule

bind gphy_cfg_reg gphy_cfg_reg_chk #(
    .DATA_W(DATA_W), .TM_LSB(TM_LSB), .CFG_LSB(CFG_LSB)
) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sw_reset(sw_reset), .an_restart(an_restart),
    .pwr_down(pwr_down), .link_up(link_up), .act_cfg(act_cfg),
    .tm_out(tm_out), .tx_clk_from_rx(tx_clk_from_rx),
    .ms_manual_en(ms_manual_en), .ms_prefer_master(ms_prefer_master)
);

// File: tb/gphy_cfg_reg_tb.sv
module gphy_cfg_reg_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        sw_reset = 1'b0, an_restart = 1'b0, pwr_down = 1'b0, link_up = 1'b0;
    logic        strap_ms = 1'b1;
    logic [1:0]  strap_aneg = 2'b01;
    logic [4:0]  act_cfg;
    logic [2:0]  tm_out;
    logic        tx_clk_from_rx, ms_manual_en, ms_force_master, ms_prefer_master;

    int vectors = 0;
    int fails   = 0;

    // behavioural reference state
    int m_tm, m_pend, m_act, m_ppd, m_plu;

    always #(CLK_PERIOD/2) clk = ~clk;

    gphy_cfg_reg dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .sw_reset(sw_reset), .an_restart(an_restart),
        .pwr_down(pwr_down), .link_up(link_up), .strap_ms(strap_ms),
        .strap_aneg(strap_aneg), .act_cfg(act_cfg), .tm_out(tm_out),
        .tx_clk_from_rx(tx_clk_from_rx), .ms_manual_en(ms_manual_en),
        .ms_force_master(ms_force_master), .ms_prefer_master(ms_prefer_master)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int reset_cfg(input int ms, input int an0);
        return (ms << 3) | (ms << 2) | (1 << 1) | an0;
    endfunction

    task automatic compare_all(input string tag);
        int eff;
        eff = (m_tm > 4) ? 0 : m_tm;
        check({tag, " R1/R2 rd_data"}, int'(rd_data), (m_tm << 13) | (m_pend << 8));
        check({tag, " R3/R4/R5 act_cfg"}, int'(act_cfg), m_act);
        check({tag, " R6 tm_out"}, int'(tm_out), eff);
        check({tag, " R8 tx_clk_from_rx"}, int'(tx_clk_from_rx), int'(eff == 2 || eff == 3));
        check({tag, " R9 ms_manual_en"}, int'(ms_manual_en), (m_act >> 4) & 1);
        check({tag, " R9 ms_force_master"}, int'(ms_force_master), ((m_act >> 4) & (m_act >> 3)) & 1);
        check({tag, " R9 ms_prefer_master"}, int'(ms_prefer_master),
              ((m_act >> 4) & 1) ? 0 : ((m_act >> 2) & 1));
    endtask

    // Apply one cycle: drive at negedge, model the edge, compare at next negedge.
    task automatic step(input logic w, input logic [15:0] d, input logic sr,
                        input logic ar, input logic pd, input logic lu);
        int ev, np;
        wr_en = w; wr_data = d; sw_reset = sr; an_restart = ar;
        pwr_down = pd; link_up = lu;
        ev = int'(sr) | int'(ar) | (m_ppd & int'(!pd)) | (m_plu & int'(!lu));
        np = w ? int'(d[12:8]) : m_pend;
        if (ev != 0) m_act = np;
        m_pend = np;
        if (ar) m_tm = 0;
        else if (w) m_tm = int'(d[15:13]);
        m_ppd = int'(pd); m_plu = int'(lu);
        @(negedge clk);
        compare_all("cyc");
    endtask

    task automatic do_reset(input logic ms, input logic [1:0] an);
        rst_n = 1'b0;
        wr_en = 0; sw_reset = 0; an_restart = 0; pwr_down = 0; link_up = 0;
        strap_ms = ms; strap_aneg = an;
        repeat (2) @(negedge clk);
        m_tm = 0; m_ppd = 0; m_plu = 0;
        m_pend = reset_cfg(int'(ms), int'(an[0]));
        m_act = m_pend;
        compare_all("reset R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("post-reset R1");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(1'b1, 2'b01);
        // R2: write held pending; low byte ignored
        step(1, 16'h10FF, 0, 0, 0, 0);
        step(0, 16'h0, 0, 0, 0, 0);
        // R3: software reset commits, keeps test mode
        step(1, 16'h4000 | 16'h1700, 0, 0, 0, 0);
        step(0, 16'h0, 1, 0, 0, 0);
        // R7: restart clears test mode and beats same-cycle write
        step(1, 16'h6000 | 16'h0A00, 0, 1, 0, 0);
        // R4: rising edges do nothing, falling edges commit
        step(1, 16'h1C00, 0, 0, 1, 1);
        step(0, 16'h0, 0, 0, 1, 1);
        step(0, 16'h0, 0, 0, 0, 1);
        step(1, 16'h0300, 0, 0, 0, 1);
        step(0, 16'h0, 0, 0, 0, 0);
        // R5: write in the same cycle as a link drop
        step(0, 16'h0, 0, 0, 0, 1);
        step(1, 16'h1F00, 0, 0, 0, 0);
        // R6: reserved codes stored but decode to 0
        for (int c = 0; c < 8; c++) step(1, 16'(c << 13), 0, 0, 0, 0);
        // second reset with other strap values (R1)
        do_reset(1'b0, 2'b10);
        do_reset(1'b1, 2'b00);
        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 3) == 0, 16'($urandom),
                 ($urandom % 9) == 0, ($urandom % 11) == 0,
                 ($urandom % 4) != 0, ($urandom % 3) != 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule